// File: doc/BRIEF.md
# Timer-Channel Serial Byte Receiver

This block receives asynchronous serial bytes (one low start bit, eight data bits sent least significant first, then a high stop level) using a single timer channel on a free-running counter instead of a dedicated baud divider. When the line is idle, the channel waits in capture mode for the falling start edge. On that edge it takes the current counter value and advances it by one and a half bit periods. The channel then switches to compare mode. Each match with the free-running counter samples the synchronized line and moves the compare value on by one bit period.

After the eighth sample the block presents the assembled byte with a one-cycle strobe, reloads its bit counter and returns to capture mode for the next start edge. Completing a byte also clears a sleep flag that a processor sets before it idles. This lets the receiver wake the processor once a whole byte is available. Bit period, half period, counter width, data width and synchronizer depth are all parameters.

Top module: `cc_uart_rx`

## Requirements
- R1: During and directly after reset, `byte_o` is 0, `byte_vld_o` is 0, `cpu_sleep_o` is 0, and the channel waits in capture mode.
- R2: A frame's data bits are assembled least significant first. The first bit after the start bit becomes bit 0 of `byte_o`.
- R3: The first sample falls one and a half bit periods after start detection, and each later sample falls one bit period after the previous one. Count as edge 1 the first rising clock edge at which `rx_i` is low. `byte_vld_o` is then high after edge 8*BIT_TICKS + HALF_TICKS + SYNC_STAGES + 1.
- R4: `byte_vld_o` is high for exactly one clock cycle per received byte.
- R5: `byte_o` changes only in the cycle in which `byte_vld_o` is high, and otherwise holds the last byte.
- R6: A high `sleep_req_i` at a clock edge sets `cpu_sleep_o`. The edge that raises `byte_vld_o` clears it.
- R7: When a sleep request and byte completion meet at the same edge, completion wins and `cpu_sleep_o` ends low.
- R8: Compare values are computed modulo 2^TMR_W and matched by equality. Reception works the same whatever the counter phase at the start edge, including when the sample points wrap past zero.
- R9: Falling edges on the line while data bits are being sampled neither restart nor shift the frame. The channel returns to capture mode at the eighth sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the timer and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| sleep_req_i | input | 1 | Processor request to enter its sleep state |
| byte_o | output | DATA_W | Last received byte, held between strobes |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte |
| cpu_sleep_o | output | 1 | Sleep state flag; completion of a byte clears it |

## Verification
The assertions assume that `rx_i` carries well-formed frames whose bit length matches BIT_TICKS, with the stop level held high at least until the eighth sample point. They also assume that reset is held for several cycles before the first edge. The stimulus keeps to this by building every frame cycle by cycle from the configured bit period, with no jitter and a high stop bit. It places random idle gaps between frames, so the start edge lands at many counter phases. The random gaps and a small counter width push sample points across the wrap. Directed bytes with alternating bits put falling edges inside the data field.

// File: rtl/cc_rx_pkg.sv
package cc_rx_pkg;
   typedef enum logic {
      CH_CAPTURE = 1'b0,
      CH_COMPARE = 1'b1
   } ch_mode_e;
endpackage

// File: rtl/cc_rx_sync.sv
module cc_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cc_rx_timer.sv
module cc_rx_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_o <= '0;
      else        count_o <= count_o + W'(1);
   end
endmodule

// File: rtl/cc_rx_channel.sv
module cc_rx_channel
   import cc_rx_pkg::*;
#(
   parameter int W    = 16,
   parameter int BIT  = 104,
   parameter int HALF = 52
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] tmr_i,
   input  logic         start_i,
   input  logic         done_i,
   output ch_mode_e     mode_o,
   output logic [W-1:0] cmp_o,
   output logic         hit_o
);
   localparam logic [W-1:0] FIRST_OFS = W'(BIT + HALF);
   localparam logic [W-1:0] STEP_OFS  = W'(BIT);

   ch_mode_e     mode;
   logic [W-1:0] cmp;

   assign hit_o  = (mode == CH_COMPARE) && (tmr_i == cmp);
   assign mode_o = mode;
   assign cmp_o  = cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= CH_CAPTURE;
         cmp  <= '0;
      end else begin
         case (mode)
            CH_CAPTURE: begin
               if (start_i) begin
                  cmp  <= tmr_i + FIRST_OFS;
                  mode <= CH_COMPARE;
               end
            end
            default: begin
               if (hit_o) begin
                  cmp <= cmp + STEP_OFS;
                  if (done_i) mode <= CH_CAPTURE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cc_rx_shifter.sv
module cc_rx_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit_i,
   input  logic          bit_i,
   output logic          last_o,
   output logic [DW-1:0] byte_o,
   output logic          vld_o
);
   localparam int CNT_W = $clog2(DW + 1);

   logic [CNT_W-1:0] left;
   logic [DW-1:0]    sh;
   logic [DW-1:0]    sh_nxt;

   assign sh_nxt = {bit_i, sh[DW-1:1]};
   assign last_o = hit_i && (left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left   <= CNT_W'(DW);
         sh     <= '0;
         byte_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (hit_i) begin
            sh <= sh_nxt;
            if (last_o) begin
               left   <= CNT_W'(DW);
               byte_o <= sh_nxt;
               vld_o  <= 1'b1;
            end else begin
               left <= left - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cc_uart_rx.sv
module cc_uart_rx
   import cc_rx_pkg::*;
#(
   parameter int TMR_W       = 16,
   parameter int BIT_TICKS   = 104,
   parameter int HALF_TICKS  = 52,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              sleep_req_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic              cpu_sleep_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cc_uart_rx: SYNC_STAGES must be at least 2");
      end
      if (HALF_TICKS < 1 || HALF_TICKS >= BIT_TICKS) begin : g_bad_half
         $error("cc_uart_rx: HALF_TICKS must lie in 1..BIT_TICKS-1");
      end
      if (BIT_TICKS + HALF_TICKS >= (1 << TMR_W)) begin : g_bad_width
         $error("cc_uart_rx: timer too narrow for one and a half bit periods");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("cc_uart_rx: DATA_W must be at least 2");
      end
   endgenerate

   logic             rx_s;
   logic             rx_prev;
   logic             rx_fall;
   logic [TMR_W-1:0] tmr_val;
   logic [TMR_W-1:0] cmp_val;
   ch_mode_e         ch_mode;
   logic             sample_hit;
   logic             frame_done;

   cc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= rx_s;
   end
   assign rx_fall = rx_prev & ~rx_s;

   cc_rx_timer #(.W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (tmr_val)
   );

   cc_rx_channel #(.W(TMR_W), .BIT(BIT_TICKS), .HALF(HALF_TICKS)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmr_i   (tmr_val),
      .start_i (rx_fall),
      .done_i  (frame_done),
      .mode_o  (ch_mode),
      .cmp_o   (cmp_val),
      .hit_o   (sample_hit)
   );

   cc_rx_shifter #(.DW(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (sample_hit),
      .bit_i  (rx_s),
      .last_o (frame_done),
      .byte_o (byte_o),
      .vld_o  (byte_vld_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cpu_sleep_o <= 1'b0;
      else if (frame_done)  cpu_sleep_o <= 1'b0;
      else if (sleep_req_i) cpu_sleep_o <= 1'b1;
   end
endmodule

// File: rtl/cc_rx_chk.sv
module cc_rx_chk #(
   parameter int W  = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vld,
   input logic [DW-1:0] data,
   input logic          sleep,
   input logic          in_cmp,
   input logic [W-1:0]  tmr,
   input logic [W-1:0]  cmp
);
   // R4
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);

   // R5
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> $stable(data));

   // R6
   sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> !sleep);

   // R9
   back_to_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> !in_cmp);

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cmp && tmr != cmp) |=> in_cmp);

   // R3
   cmp_moves_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cmp && tmr != cmp) |=> $stable(cmp));
endmodule

bind cc_uart_rx cc_rx_chk #(.W(TMR_W), .DW(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .vld    (byte_vld_o),
   .data   (byte_o),
   .sleep  (cpu_sleep_o),
   .in_cmp (ch_mode == cc_rx_pkg::CH_COMPARE),
   .tmr    (tmr_val),
   .cmp    (cmp_val)
);

// File: tb/test_cc_uart_rx.sv
module test_cc_uart_rx;
   localparam int CLK_PERIOD = 10;
   localparam int TW   = 6;
   localparam int BIT  = 16;
   localparam int HALF = 8;
   localparam int DW   = 8;
   localparam int SYNC = 2;
   localparam int LAT  = 8 * BIT + HALF + SYNC + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_i = 1'b1;
   logic          sleep_req_i = 1'b0;
   logic [DW-1:0] byte_o;
   logic          byte_vld_o;
   logic          cpu_sleep_o;

   int            n_chk = 0;
   int            n_fail = 0;
   logic [DW-1:0] prev_byte = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cc_uart_rx #(
      .TMR_W(TW), .BIT_TICKS(BIT), .HALF_TICKS(HALF),
      .DATA_W(DW), .SYNC_STAGES(SYNC)
   ) i_cc_uart_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_i        (rx_i),
      .sleep_req_i (sleep_req_i),
      .byte_o      (byte_o),
      .byte_vld_o  (byte_vld_o),
      .cpu_sleep_o (cpu_sleep_o)
   );

   function automatic logic line_level(input logic [DW-1:0] b, input int i);
      int slot = i / BIT;
      if (slot == 0)  return 1'b0;
      if (slot <= DW) return b[slot-1];
      return 1'b1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic [DW-1:0] b, input int gap,
                            input bit sleep_before, input bit sleep_at_done,
                            input string tag);
      int   seen = 0;
      int   seen_at = -1;
      int   got = 0;
      bit   held_ok = 1'b1;
      bit   sleep_ok = 1'b1;
      int   total = (DW + 2) * BIT + gap;
      if (sleep_before) begin
         @(negedge clk); sleep_req_i = 1'b1;
         @(negedge clk); sleep_req_i = 1'b0;
         check(cpu_sleep_o == 1'b1, "R6 sleep set", int'(cpu_sleep_o), 1);
      end
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (byte_vld_o) begin
               seen++;
               seen_at = i;
               got = int'(byte_o);
               if (cpu_sleep_o) sleep_ok = 1'b0;
            end else if (seen == 0) begin
               if (byte_o !== prev_byte) held_ok = 1'b0;
               if (sleep_before && !cpu_sleep_o) sleep_ok = 1'b0;
            end
         end
         rx_i = line_level(b, i);
         sleep_req_i = sleep_at_done && (i == LAT - 1);
      end
      sleep_req_i = 1'b0;
      check(seen == 1, {"R4 one strobe ", tag}, seen, 1);
      check(got == int'(b), {"R2 byte value ", tag}, got, int'(b));
      check(seen_at == LAT, {"R3 R8 strobe cycle ", tag}, seen_at, LAT);
      check(held_ok, {"R5 byte held ", tag}, int'(byte_o), int'(prev_byte));
      if (sleep_before)
         check(sleep_ok && !cpu_sleep_o, {"R6 sleep cleared ", tag}, int'(cpu_sleep_o), 0);
      if (sleep_at_done)
         check(!cpu_sleep_o, {"R7 completion wins ", tag}, int'(cpu_sleep_o), 0);
      prev_byte = b;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: values held in reset
      check(byte_o == '0 && !byte_vld_o && !cpu_sleep_o, "R1 in reset",
            int'(byte_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(byte_o == '0 && !byte_vld_o && !cpu_sleep_o, "R1 after reset",
            int'(byte_o), 0);

      // directed corner bytes; alternating patterns put falling edges in data (R9)
      run_frame(8'h55, 0,  1'b0, 1'b0, "R9 0x55");
      run_frame(8'hAA, 3,  1'b0, 1'b0, "R9 0xAA");
      run_frame(8'h00, 5,  1'b1, 1'b0, "0x00");
      run_frame(8'hFF, 1,  1'b0, 1'b0, "0xFF");
      run_frame(8'h01, 7,  1'b0, 1'b1, "0x01");
      run_frame(8'h80, 11, 1'b1, 1'b0, "0x80");

      // random bytes and idle gaps spread the timer phase over its wrap (R8)
      for (int k = 0; k < 24; k++) begin
         run_frame(8'($urandom), int'($urandom_range(0, 3 * BIT)),
                   1'($urandom_range(0, 1)), 1'b0, "R8 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule